// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block produces the word address for a synchronous burst SRAM. A start strobe captures an external address as the first beat of a four-beat burst. The upper address bits stay fixed for the rest of the burst. The two low bits then come from a 2-bit beat counter. That counter moves forward only in cycles where the advance input is asserted, so a burst can pause for any number of cycles.

There are two active-low start strobes. One is the processor strobe, which is honoured only while the first chip enable is asserted. The other is the controller strobe, which is always honoured. When both strobes are honoured in the same cycle, the processor strobe wins. A load may occur in any cycle, including the cycle after another load or partway through a burst. The order-select input chooses between two beat orders: low gives a linear order (start plus beat count, modulo four), and high gives an interleaved order (start XOR beat count). An unused order-select input should be tied high, so that interleaved order is the default.

The sequencer also decodes the three chip enables into a selected flag. It captures that flag on every load and holds it until the next load. A one-hot start-kind output reports, for one cycle, which strobe started the burst now on the address output.

Top module: `burst_seq_top`

## Requirements
- R1: While reset is asserted and right after its release, with no strobe asserted, `word_addr` is 0, `selected` is 0 and `start_kind` is 2'b00.
- R2: A processor strobe (`cpu_strb_n`=0) sampled while `en1_n`=0 loads `addr_in`. In the next cycle `word_addr` equals the sampled `addr_in` and `start_kind` is 2'b01.
- R3: A processor strobe sampled while `en1_n`=1 is ignored. No load occurs, `start_kind` stays 2'b00, and `word_addr` holds or advances exactly as if the strobe had been deasserted.
- R4: A controller strobe (`ctl_strb_n`=0) loads `addr_in` whatever the processor strobe and the enables are doing. In the next cycle `word_addr` equals the sampled `addr_in` and `start_kind` is 2'b10.
- R5: When no load occurs, `adv_n`=0 moves the beat count up by one and `adv_n`=1 leaves `word_addr` unchanged.
- R6: With `order_sel`=0, the two low bits of `word_addr` equal (start low bits + beat count) mod 4.
- R7: With `order_sel`=1, the two low bits of `word_addr` equal start low bits XOR beat count. For example, a start of 1 gives the sequence 1,0,3,2.
- R8: After the fourth beat, the count wraps back to the start value within the same group of four. Bits [AW-1:2] of `word_addr` never change without a load.
- R9: On every load, `selected` captures (`en1_n`==0 && `en2`==1 && `en3_n`==0) as sampled in the load cycle. It holds that value until the next load, whatever the enables do in between.
- R10: A load takes priority over advance, and back-to-back loads each show their own address one cycle later.
- R11: When both strobes are honoured in the same cycle, the processor strobe wins (`start_kind` 2'b01). `start_kind` is never 2'b11, and it returns to 2'b00 in any cycle that follows a cycle without a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | AW | External start address |
| cpu_strb_n | input | 1 | Processor start strobe, active low, gated by en1_n |
| ctl_strb_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Beat advance, active low |
| en1_n | input | 1 | Chip enable 1, active low |
| en2 | input | 1 | Chip enable 2, active high |
| en3_n | input | 1 | Chip enable 3, active low |
| order_sel | input | 1 | Beat order: 1 interleaved, 0 linear |
| word_addr | output | AW | Current burst word address |
| selected | output | 1 | Chip-enable decode captured at the last load |
| start_kind | output | 2 | One-cycle start marker: 01 processor, 10 controller |

## Verification
The bench sweeps both orders, both strobes, every start offset and several upper-address patterns. Each burst runs past its fourth beat, so a design that carried into the upper bits or mixed up the two orders gives a wrong address on some beat. A pause in the middle of each burst catches a counter that moves without the advance input. Separate cases target the strobe corners: a gated processor strobe that wrongly loads, both strobes at once reporting the wrong winner, and a controller strobe blocked by the processor gate. All eight enable combinations are checked for the captured selected flag, which must not follow the enables between loads. Back-to-back loads with advance asserted expose a counter that steps on a load cycle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int LOW_W = 2;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_PROC = 2'b01,
    SRC_CTRL = 2'b10
  } src_e;

  function automatic logic [LOW_W-1:0] lin_low(input logic [LOW_W-1:0] start,
                                               input logic [LOW_W-1:0] cnt);
    return start + cnt;
  endfunction

  function automatic logic [LOW_W-1:0] ilv_low(input logic [LOW_W-1:0] start,
                                               input logic [LOW_W-1:0] cnt);
    return start ^ cnt;
  endfunction

  function automatic logic [LOW_W-1:0] beat_low(input logic ilv,
                                                input logic [LOW_W-1:0] start,
                                                input logic [LOW_W-1:0] cnt);
    return ilv ? ilv_low(start, cnt) : lin_low(start, cnt);
  endfunction
endpackage

// File: rtl/bseq_strobe_arb.sv
module bseq_strobe_arb
  import burst_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_strb_n,
  input  logic ctl_strb_n,
  input  logic en1_n,
  output src_e src,
  output logic load
);
  logic proc_ok;
  logic ctrl_ok;

  assign proc_ok = !cpu_strb_n && !en1_n;
  assign ctrl_ok = !ctl_strb_n;

  always_comb begin
    if (proc_ok)      src = SRC_PROC;
    else if (ctrl_ok) src = SRC_CTRL;
    else              src = SRC_NONE;
  end

  assign load = (src != SRC_NONE);

  // R3: a gated processor strobe alone never produces a load
  p_gated_cpu_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en1_n && ctl_strb_n) |-> !load);

  // R4: the controller strobe always produces a load
  p_ctl_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_strb_n |-> load);
endmodule

// File: rtl/bseq_sel_dec.sv
module bseq_sel_dec (
  input  logic en1_n,
  input  logic en2,
  input  logic en3_n,
  output logic sel_now
);
  assign sel_now = !en1_n && en2 && !en3_n;
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
  import burst_seq_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          order_ilv,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] word_addr
);
  localparam int UW = AW - LOW_W;

  logic [AW-1:0]    base_q;
  logic [LOW_W-1:0] cnt_q;
  logic [UW-1:0]    upper;
  logic [LOW_W-1:0] low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= addr_in;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign upper     = base_q[AW-1:LOW_W];
  assign low       = beat_low(order_ilv, base_q[LOW_W-1:0], cnt_q);
  assign word_addr = {upper, low};

  // R8: upper bits change only through a load
  p_upper_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(word_addr[AW-1:LOW_W]));

  // R5: with no load and no advance the address holds (order unchanged)
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> (!$stable(order_ilv) || $stable(word_addr)));

  // R6: in linear order an advance adds one to the low bits
  p_lin_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && !order_ilv) |=>
      (order_ilv || word_addr[LOW_W-1:0] == LOW_W'($past(word_addr[LOW_W-1:0]) + 1'b1)));

  // R2: a load shows the sampled address next cycle
  p_load_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> word_addr == $past(addr_in));
endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
  import burst_seq_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic          cpu_strb_n,
  input  logic          ctl_strb_n,
  input  logic          adv_n,
  input  logic          en1_n,
  input  logic          en2,
  input  logic          en3_n,
  input  logic          order_sel,
  output logic [AW-1:0] word_addr,
  output logic          selected,
  output logic [1:0]    start_kind
);
  src_e src_evt;
  logic load_evt;
  logic step_evt;
  logic sel_now;
  logic sel_q;
  logic [1:0] kind_q;

  bseq_strobe_arb arb_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_strb_n (cpu_strb_n),
    .ctl_strb_n (ctl_strb_n),
    .en1_n      (en1_n),
    .src        (src_evt),
    .load       (load_evt)
  );

  bseq_sel_dec dec_i (
    .en1_n   (en1_n),
    .en2     (en2),
    .en3_n   (en3_n),
    .sel_now (sel_now)
  );

  assign step_evt = !adv_n;

  bseq_beat_ctr #(.AW(AW)) ctr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_evt),
    .step      (step_evt),
    .order_ilv (order_sel),
    .addr_in   (addr_in),
    .word_addr (word_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      kind_q <= 2'b00;
    end else begin
      kind_q <= src_evt;
      if (load_evt) sel_q <= sel_now;
    end
  end

  assign selected   = sel_q;
  assign start_kind = kind_q;

  // R11: start marker is at most one-hot
  p_kind_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_kind));

  // R11: an honoured processor strobe wins over the controller
  p_proc_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_strb_n && !en1_n) |=> start_kind == 2'b01);

  // R9: selected only moves on a load
  p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(selected));
endmodule

// File: tb/burst_seq_top_tb_top.sv
module burst_seq_top_tb_top;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          cpu_strb_n = 1'b1;
  logic          ctl_strb_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          en1_n = 1'b0;
  logic          en2 = 1'b1;
  logic          en3_n = 1'b0;
  logic          order_sel = 1'b1;
  logic [AW-1:0] word_addr;
  logic          selected;
  logic [1:0]    start_kind;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  burst_seq_top #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .adv_n(adv_n),
    .en1_n(en1_n), .en2(en2), .en3_n(en3_n), .order_sel(order_sel),
    .word_addr(word_addr), .selected(selected), .start_kind(start_kind)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic p, input logic c, input logic a,
                     input logic e1, input logic e2v, input logic e3,
                     input logic [AW-1:0] ad);
    cpu_strb_n = p; ctl_strb_n = c; adv_n = a;
    en1_n = e1; en2 = e2v; en3_n = e3; addr_in = ad;
    @(posedge clk);
    #1;
    cpu_strb_n = 1'b1; ctl_strb_n = 1'b1; adv_n = 1'b1;
  endtask

  // expected low bits, worked out per bit / by arithmetic
  function automatic int exp_low(input int ilv, input int s, input int k);
    int r;
    if (ilv != 0) begin
      r = 0;
      for (int b = 0; b < 2; b++)
        if (((s >> b) & 1) != ((k >> b) & 1)) r = r + (1 << b);
      return r;
    end
    return (s + k) % 4;
  endfunction

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int ups[3];
    ups[0] = 0; ups[1] = 'h15; ups[2] = 'h3f;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 addr in reset", word_addr, 0);
    chk("R1 sel in reset", selected, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 addr", word_addr, 0);
    chk("R1 sel", selected, 0);
    chk("R1 kind", start_kind, 0);

    // Sweep: order x strobe x start offset x upper bits (R2 R4 R5 R6 R7 R8)
    for (int o = 0; o < 2; o++) begin
      for (int kd = 0; kd < 2; kd++) begin
        for (int s = 0; s < 4; s++) begin
          for (int u = 0; u < 3; u++) begin
            int ad;
            ad = (ups[u] << 2) | s;
            order_sel = o[0];
            if (kd == 0) cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, AW'(ad));
            else         cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, AW'(ad));
            chk(kd == 0 ? "R2 load addr" : "R4 load addr", word_addr, ad);
            chk(kd == 0 ? "R2 kind" : "R4 kind", start_kind, kd == 0 ? 1 : 2);
            chk("R9 sel on load", selected, 1);
            for (int k = 1; k <= 5; k++) begin
              if (k == 3) begin
                cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
                chk("R5 hold", word_addr, (ups[u] << 2) | exp_low(o, s, 2));
              end
              cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
              chk(o != 0 ? "R7 interleaved beat" : "R6 linear beat",
                  word_addr & 3, exp_low(o, s, k % 4));
              chk("R8 upper fixed/wrap", word_addr >> 2, ups[u]);
              if (k == 1) chk("R11 kind clears", start_kind, 0);
            end
          end
        end
      end
    end

    // R3: gated processor strobe ignored
    order_sel = 1'b0;
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'hA4);
    chk("R4 load A4", word_addr, 'hA4);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h3B);
    chk("R3 no load addr", word_addr, 'hA4);
    chk("R3 no kind", start_kind, 0);
    chk("R3 sel kept", selected, 1);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h3B);
    chk("R3 advances instead", word_addr, 'hA5);

    // R11: both strobes
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h37);
    chk("R11 proc wins kind", start_kind, 1);
    chk("R11 proc wins addr", word_addr, 'h37);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h5A);
    chk("R11 gated proc, ctrl kind", start_kind, 2);
    chk("R4 ctrl addr under gate", word_addr, 'h5A);
    chk("R9 deselected", selected, 0);

    // R9: all enable combinations
    for (int i = 0; i < 8; i++) begin
      cyc(1'b1, 1'b0, 1'b1, i[0], i[1], i[2], AW'(i));
      chk("R9 decode", selected, (i == 2) ? 1 : 0);
    end
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h40);
    chk("R9 sel set", selected, 1);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
    chk("R9 sel held", selected, 1);

    // R10: back-to-back loads with advance asserted
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h10);
    chk("R10 load 10", word_addr, 'h10);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h23);
    chk("R10 load 23", word_addr, 'h23);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFE);
    chk("R10 load FE", word_addr, 'hFE);
    chk("R10 kind", start_kind, 1);

    finish_run();
  end
endmodule